// File: doc/BRIEF.md
# Radio Transceiver Serial Access Port

This block is the host-facing serial port of a low-rate wireless transceiver. An SPI master reaches a 64-entry byte register space and a frame memory through it. Every transaction opens with a command byte. Its top bits choose one of three things: a single register read or write, a burst that fills the frame memory, or a burst that reads the frame memory back. While the command byte shifts in, the port shifts out the current transceiver state.

The register space has three kinds of address. Writable control registers hold what the host writes. Read-only registers report live inputs, fixed identity values or the interrupt status. All remaining addresses are unimplemented. Interrupt sources set sticky status bits, and a read of the status register clears them. The interrupt pin is driven from the status bits that are also enabled in the mask, and a control bit sets its active level. The transceiver state, the transaction status, the signal strength and the link quality all arrive as plain inputs.

The serial pins are sampled with the system clock, so each SCLK half-period must last at least four system clocks.

Top module: `rfspi_top`

## Requirements
- R1: The port uses SPI mode 0 with MSB first. While the command byte shifts in, MISO returns {3'b000, trx_state_i}. This is the same value that register 0x01 holds.
- R2: A command byte of 0x80|addr reads the register and returns its value in the next byte. A command byte of 0xC0|addr writes the next byte to the register. Any further bytes in a register transaction are ignored, and MISO returns 0x00 during them.
- R3: Addresses 0x01, 0x06, 0x0F and 0x1C to 0x1F are read-only, and writes to them are ignored. Reads return fixed or live values: 0x06 gives rssi_i, 0x1C gives PART_ID, 0x1D gives VERSION_ID, 0x1E gives 0x1F and 0x1F gives 0x00.
- R4: Unimplemented addresses, such as 0x13 and 0x30 to 0x3F, always read 0x00, and writes to them are ignored.
- R5: Bits 4:0 of register 0x02 store the state command and drive trx_cmd_o. A read of register 0x02 returns trac_i in bits 7:5.
- R6: A one-cycle pulse on bit n of irq_src_i sets bit n of the interrupt status register 0x0F. The bit stays set until that register is read.
- R7: A read of register 0x0F returns the pending bits and then clears them. A source pulse that arrives in the clearing cycle stays set.
- R8: The interrupt condition is true when (status & mask) is nonzero, where the mask is register 0x0E. Bit 0 of register 0x04 sets the pin level: 0 means irq_o is high when the condition is true, and 1 means irq_o is low when it is true. With no enabled status bit pending, irq_o equals that polarity bit.
- R9: Command 0x60 writes the frame memory. The first data byte is the length, stored with bit 7 dropped, and the bytes after it are payload in order.
- R10: Command 0x20 reads the frame memory. MISO returns the length byte, then that many payload bytes, then lqi_i, and 0x00 after that.
- R11: The frame memory holds at most 127 payload bytes. Payload bytes beyond 127 in one write are dropped.
- R12: Raising chip select aborts the transaction and discards any partly shifted byte. An aborted frame write keeps the length and the payload bytes it received in full, and later payload positions keep their old contents. A register write whose data byte is incomplete changes nothing.
- R13: A command byte with bits 7 and 5 both clear is ignored. MISO returns 0x00 for the rest of that transaction, and no register or frame state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| trx_state_i | input | 5 | Current transceiver state code |
| trac_i | input | 3 | Transaction status code |
| rssi_i | input | 8 | Signal strength value, read through register 0x06 |
| lqi_i | input | 8 | Link quality byte appended to frame reads |
| irq_src_i | input | 8 | Interrupt source pulses, one bit per status bit |
| irq_o | output | 1 | Interrupt pin, polarity set by register 0x04 bit 0 |
| trx_cmd_o | output | 5 | Stored state command from register 0x02 |

## Verification
The bench writes the identity and status registers and reads them back. A design that lets a write reach a read-only or unimplemented address returns the written value instead of the fixed value or zero. For the interrupt pin, the bench pulses both masked and unmasked sources under each polarity. A wrong mask or polarity shows as a pin at the wrong level, and a missing clear-on-read shows as a pin that stays asserted after the read. Frame tests write an over-long payload, write a length with bit 7 set, and abort a burst partway. A design that wraps the write index corrupts the first payload bytes. One that appends the link-quality byte at the wrong position returns it at the wrong offset. One that commits a partial byte or resets the frame on abort returns the wrong bytes after the cut.

// File: rtl/rfspi_pkg.sv
package rfspi_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NREG   = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_STATUS = 6'h01;
  localparam logic [ADDR_W-1:0] A_STCMD  = 6'h02;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h04;
  localparam logic [ADDR_W-1:0] A_RSSI   = 6'h06;
  localparam logic [ADDR_W-1:0] A_IMASK  = 6'h0E;
  localparam logic [ADDR_W-1:0] A_ISTAT  = 6'h0F;
  localparam logic [ADDR_W-1:0] A_PART   = 6'h1C;
  localparam logic [ADDR_W-1:0] A_VER    = 6'h1D;
  localparam logic [ADDR_W-1:0] A_MID0   = 6'h1E;
  localparam logic [ADDR_W-1:0] A_MID1   = 6'h1F;

  typedef enum logic [2:0] {
    M_IDLE, M_REG_RD, M_REG_WR, M_FB_RD, M_FB_WR, M_SKIP
  } mode_e;

  // Writable control registers; everything else is read-only or absent.
  function automatic logic is_writable(input logic [ADDR_W-1:0] a);
    case (a) inside
      [6'h02:6'h05], [6'h07:6'h0E], [6'h10:6'h12],
      6'h15, 6'h17, 6'h18, 6'h1A, 6'h1B, [6'h20:6'h2F]: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Command byte: bit 7 register access, bit 6 write, bit 5 frame access.
  function automatic mode_e decode_cmd(input logic [DATA_W-1:0] c);
    if (c[7])      return c[6] ? M_REG_WR : M_REG_RD;
    else if (c[5]) return c[6] ? M_FB_WR  : M_FB_RD;
    else           return M_SKIP;
  endfunction

  // Frame read stream: position 0 is the length, then payload, then link quality.
  function automatic logic [DATA_W-1:0] fb_pick(input logic [7:0] k,
                                                input logic [7:0] len,
                                                input logic [7:0] pay,
                                                input logic [7:0] lqi);
    if (k == 8'd0)                           return len;
    else if (k <= len)                       return pay;
    else if ({1'b0, k} == ({1'b0, len} + 9'd1)) return lqi;
    else                                     return '0;
  endfunction
endpackage

// File: rtl/rfspi_shift.sv
module rfspi_shift #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  output logic             miso_o,
  input  logic [7:0]       tx_first,
  input  logic [7:0]       tx_next,
  output logic             sel_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             byte_done_o,
  output logic [7:0]       rx_byte_o,
  output logic [IDX_W-1:0] byte_idx_o
);
  logic [1:0] sclk_s, cs_s, mosi_s;
  logic       sclk_q, cs_q;
  logic       rise, fall;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 2'b00; cs_s <= 2'b11; mosi_s <= 2'b00;
      sclk_q <= 1'b0;  cs_q <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[0], sclk_i};
      cs_s   <= {cs_s[0], cs_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
      sclk_q <= sclk_s[1];
      cs_q   <= cs_s[1];
    end
  end

  assign sel_o   = ~cs_s[1];
  assign start_o = ~cs_s[1] & cs_q;
  assign stop_o  = cs_s[1] & ~cs_q;
  assign rise    = sclk_s[1] & ~sclk_q;
  assign fall    = ~sclk_s[1] & sclk_q;
  assign miso_o  = sel_o & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0;
      rx_byte_o <= '0; byte_done_o <= 1'b0; byte_idx_o <= '0;
    end else begin
      byte_done_o <= 1'b0;
      if (byte_done_o && byte_idx_o != '1) byte_idx_o <= byte_idx_o + 1'b1;
      if (start_o) begin
        bit_cnt <= '0;
        byte_idx_o <= '0;
        tx_sh <= tx_first;
      end else if (sel_o) begin
        if (rise) begin
          rx_sh   <= {rx_sh[5:0], mosi_s[1]};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) begin
            rx_byte_o   <= {rx_sh, mosi_s[1]};
            byte_done_o <= 1'b1;
          end
        end
        if (fall) tx_sh <= (bit_cnt == 3'd0) ? tx_next : {tx_sh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/rfspi_regs.sv
module rfspi_regs
  import rfspi_pkg::*;
#(
  parameter logic [7:0] PART_ID    = 8'h03,
  parameter logic [7:0] VERSION_ID = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_clr,
  input  logic [7:0]        irq_set,
  input  logic [4:0]        trx_state,
  input  logic [2:0]        trac,
  input  logic [7:0]        rssi,
  output logic [7:0]        rd_data,
  output logic [7:0]        irq_status_o,
  output logic [7:0]        irq_mask_o,
  output logic              irq_pol_o,
  output logic              irq_o,
  output logic [4:0]        trx_cmd_o
);
  logic [7:0] mem [NREG];
  logic [7:0] istat;
  logic       istat_clr;

  assign istat_clr = rd_clr && (rd_addr == A_ISTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      istat <= '0;
    end else begin
      if (wr_en && is_writable(wr_addr)) mem[wr_addr] <= wr_data;
      istat <= (istat_clr ? 8'h00 : istat) | irq_set;
    end
  end

  always_comb begin
    case (rd_addr)
      A_STATUS: rd_data = {3'b000, trx_state};
      A_STCMD:  rd_data = {trac, mem[A_STCMD][4:0]};
      A_RSSI:   rd_data = rssi;
      A_ISTAT:  rd_data = istat;
      A_PART:   rd_data = PART_ID;
      A_VER:    rd_data = VERSION_ID;
      A_MID0:   rd_data = 8'h1F;
      A_MID1:   rd_data = 8'h00;
      default:  rd_data = is_writable(rd_addr) ? mem[rd_addr] : 8'h00;
    endcase
  end

  assign irq_status_o = istat;
  assign irq_mask_o   = mem[A_IMASK];
  assign irq_pol_o    = mem[A_CTRL][0];
  assign irq_o        = (|(istat & mem[A_IMASK])) ^ mem[A_CTRL][0];
  assign trx_cmd_o    = mem[A_STCMD][4:0];
endmodule

// File: rtl/rfspi_fbuf.sv
module rfspi_fbuf #(
  parameter int PAY_MAX = 127,
  localparam int PIDX_W = $clog2(PAY_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_we,
  input  logic              pay_we,
  input  logic [7:0]        wdata,
  input  logic [PIDX_W-1:0] pay_widx,
  input  logic [PIDX_W-1:0] pay_ridx,
  output logic [7:0]        len_o,
  output logic [7:0]        pay_o
);
  logic [7:0] mem [PAY_MAX];
  logic [7:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAY_MAX; i++) mem[i] <= '0;
      len_q <= '0;
    end else begin
      if (len_we) len_q <= {1'b0, wdata[6:0]};
      if (pay_we && (int'(pay_widx) < PAY_MAX)) mem[pay_widx] <= wdata;
    end
  end

  assign len_o = len_q;
  assign pay_o = (int'(pay_ridx) < PAY_MAX) ? mem[pay_ridx] : 8'h00;
endmodule

// File: rtl/rfspi_top.sv
module rfspi_top
  import rfspi_pkg::*;
#(
  parameter logic [7:0] PART_ID    = 8'h03,
  parameter logic [7:0] VERSION_ID = 8'h02,
  parameter int         PAY_MAX    = 127,
  localparam int        PIDX_W     = $clog2(PAY_MAX),
  localparam int        IDX_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic [4:0] trx_state_i,
  input  logic [2:0] trac_i,
  input  logic [7:0] rssi_i,
  input  logic [7:0] lqi_i,
  input  logic [7:0] irq_src_i,
  output logic       irq_o,
  output logic [4:0] trx_cmd_o
);
  logic             sel, start, stop, byte_done;
  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       tx_first, next_tx;

  mode_e             mode, cmd_mode;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        k_q;

  // Named events shared with the checker.
  logic              rd_clr, reg_we, fb_len_we, fb_pay_we;
  logic [ADDR_W-1:0] rd_addr;
  logic [PIDX_W-1:0] fb_widx, fb_ridx;
  logic [7:0]        reg_rdata, fb_len, fb_pay, fb_byte;
  logic [7:0]        irq_status, irq_mask;
  logic              irq_pol;

  assign tx_first = {3'b000, trx_state_i};

  rfspi_shift #(.IDX_W(IDX_W)) u_shift (
    .clk, .rst_n, .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .miso_o(spi_miso), .tx_first, .tx_next(next_tx), .sel_o(sel),
    .start_o(start), .stop_o(stop), .byte_done_o(byte_done),
    .rx_byte_o(rx_byte), .byte_idx_o(byte_idx)
  );

  assign cmd_mode  = decode_cmd(rx_byte);
  assign rd_addr   = rx_byte[ADDR_W-1:0];
  assign rd_clr    = byte_done && (byte_idx == '0) && (cmd_mode == M_REG_RD);
  assign reg_we    = byte_done && (byte_idx == IDX_W'(1)) && (mode == M_REG_WR);
  assign fb_len_we = byte_done && (byte_idx == IDX_W'(1)) && (mode == M_FB_WR);
  assign fb_pay_we = byte_done && (byte_idx >= IDX_W'(2)) &&
                     (int'(byte_idx) < PAY_MAX + 2) && (mode == M_FB_WR);
  assign fb_widx   = PIDX_W'(byte_idx - IDX_W'(2));
  assign fb_ridx   = PIDX_W'(k_q - 8'd1);
  assign fb_byte   = fb_pick(k_q, fb_len, fb_pay, lqi_i);

  rfspi_regs #(.PART_ID(PART_ID), .VERSION_ID(VERSION_ID)) u_regs (
    .clk, .rst_n, .wr_en(reg_we), .wr_addr(addr_q), .wr_data(rx_byte),
    .rd_addr, .rd_clr, .irq_set(irq_src_i), .trx_state(trx_state_i),
    .trac(trac_i), .rssi(rssi_i), .rd_data(reg_rdata),
    .irq_status_o(irq_status), .irq_mask_o(irq_mask), .irq_pol_o(irq_pol),
    .irq_o, .trx_cmd_o
  );

  rfspi_fbuf #(.PAY_MAX(PAY_MAX)) u_fbuf (
    .clk, .rst_n, .len_we(fb_len_we), .pay_we(fb_pay_we), .wdata(rx_byte),
    .pay_widx(fb_widx), .pay_ridx(fb_ridx), .len_o(fb_len), .pay_o(fb_pay)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; addr_q <= '0; k_q <= '0; next_tx <= '0;
    end else if (start) begin
      mode <= M_IDLE; k_q <= '0; next_tx <= '0;
    end else if (stop) begin
      mode <= M_IDLE;
    end else if (byte_done) begin
      if (byte_idx == '0) begin
        mode   <= cmd_mode;
        addr_q <= rd_addr;
      end
      if ((byte_idx == '0 && cmd_mode == M_FB_RD) ||
          (byte_idx != '0 && mode == M_FB_RD)) begin
        next_tx <= fb_byte;
        if (k_q != 8'hFF) k_q <= k_q + 8'd1;
      end else if (byte_idx == '0 && cmd_mode == M_REG_RD) begin
        next_tx <= reg_rdata;
      end else begin
        next_tx <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/rfspi_chk.sv
module rfspi_chk #(
  parameter int PAY_MAX = 127,
  localparam int PIDX_W = $clog2(PAY_MAX)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic [7:0]        irq_status,
  input logic [7:0]        irq_mask,
  input logic              irq_pol,
  input logic              rd_clr,
  input logic [5:0]        rd_addr,
  input logic [7:0]        irq_src_i,
  input logic              fb_pay_we,
  input logic [PIDX_W-1:0] fb_widx,
  input logic              byte_done,
  input logic              sel
);
  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && rd_addr == 6'h0F) |=> (irq_status == $past(irq_src_i)));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_clr && rd_addr == 6'h0F) |=>
      ((irq_status & $past(irq_status)) == $past(irq_status)));

  a_r8_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & irq_mask) == 8'h00) |-> (irq_o == irq_pol));

  a_r11_fb_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pay_we |-> (int'(fb_widx) < PAY_MAX));

  a_r12_byte_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> sel);
endmodule

bind rfspi_top rfspi_chk #(.PAY_MAX(PAY_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .irq_status(irq_status),
  .irq_mask(irq_mask), .irq_pol(irq_pol), .rd_clr(rd_clr), .rd_addr(rd_addr),
  .irq_src_i(irq_src_i), .fb_pay_we(fb_pay_we), .fb_widx(fb_widx),
  .byte_done(byte_done), .sel(sel)
);

// File: tb/sim_rfspi_top.sv
module sim_rfspi_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NBUF       = 136;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [4:0] trx_state_i = 5'h08;
  logic [2:0] trac_i = 3'd0;
  logic [7:0] rssi_i = 8'h00, lqi_i = 8'h00, irq_src_i = 8'h00;
  logic irq_o;
  logic [4:0] trx_cmd_o;

  logic [7:0] txb [NBUF];
  logic [7:0] rxb [NBUF];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfspi_top u0 (
    .clk, .rst_n, .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso,
    .trx_state_i, .trac_i, .rssi_i, .lqi_i, .irq_src_i, .irq_o, .trx_cmd_o
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic spi_bits(input int nbits);
    for (int b = 0; b < NBUF; b++) rxb[b] = 8'h00;
    wait_clk(1);
    spi_cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = txb[i/8][7-(i%8)];
      wait_clk(HALF);
      rxb[i/8][7-(i%8)] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    txb[0] = 8'hC0 | {2'b00, a}; txb[1] = d;
    spi_bits(16);
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [7:0] d);
    txb[0] = 8'h80 | {2'b00, a}; txb[1] = 8'h00;
    spi_bits(16);
    d = rxb[1];
  endtask

  task automatic pulse_src(input logic [7:0] v);
    irq_src_i = v; wait_clk(1); irq_src_i = 8'h00; wait_clk(2);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R8 reset pin", {7'b0, irq_o}, 8'h00);
    chk("R5 reset cmd", {3'b0, trx_cmd_o}, 8'h00);
    reg_rd(6'h0E, d); chk("R8 reset mask", d, 8'h00);
  endtask

  task automatic t_status_byte;
    trx_state_i = 5'h16;
    txb[0] = 8'h80; txb[1] = 8'h00;
    spi_bits(16);
    chk("R1 status during command", rxb[0], 8'h16);
    trx_state_i = 5'h08;
  endtask

  task automatic t_reg_rw;
    logic [7:0] d;
    txb[0] = 8'hE0; txb[1] = 8'hA5; txb[2] = 8'h77;
    spi_bits(24);
    txb[0] = 8'hA0; txb[1] = 8'h00; txb[2] = 8'h00;
    spi_bits(24);
    chk("R2 read back 0x20", rxb[1], 8'hA5);
    chk("R2 extra byte returns zero", rxb[2], 8'h00);
    reg_wr(6'h2C, 8'h3C); reg_rd(6'h2C, d);
    chk("R2 read back 0x2C", d, 8'h3C);
  endtask

  task automatic t_readonly;
    logic [7:0] d;
    reg_wr(6'h1E, 8'h55); reg_rd(6'h1E, d); chk("R3 id0 fixed", d, 8'h1F);
    reg_wr(6'h1F, 8'h55); reg_rd(6'h1F, d); chk("R3 id1 fixed", d, 8'h00);
    reg_rd(6'h1C, d); chk("R3 part number", d, 8'h03);
    reg_rd(6'h1D, d); chk("R3 version", d, 8'h02);
    rssi_i = 8'h44;
    reg_wr(6'h06, 8'h99); reg_rd(6'h06, d); chk("R3 rssi live", d, 8'h44);
    trx_state_i = 5'h09;
    reg_wr(6'h01, 8'hFF); reg_rd(6'h01, d); chk("R3 state live", d, 8'h09);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    reg_wr(6'h13, 8'hFF); reg_rd(6'h13, d); chk("R4 0x13 reads zero", d, 8'h00);
    reg_wr(6'h30, 8'hFF); reg_rd(6'h30, d); chk("R4 0x30 reads zero", d, 8'h00);
  endtask

  task automatic t_trx_cmd;
    logic [7:0] d;
    trac_i = 3'd5;
    reg_wr(6'h02, 8'hE9);
    chk("R5 command output", {3'b0, trx_cmd_o}, 8'h09);
    reg_rd(6'h02, d); chk("R5 trac in upper bits", d, 8'hA9);
    trac_i = 3'd0;
  endtask

  task automatic t_irq;
    logic [7:0] d;
    reg_wr(6'h0E, 8'h08);
    pulse_src(8'h02);
    chk("R8 unmasked source leaves pin idle", {7'b0, irq_o}, 8'h00);
    pulse_src(8'h08);
    chk("R8 masked source raises pin", {7'b0, irq_o}, 8'h01);
    pulse_src(8'h01);
    wait_clk(5);
    chk("R6 pin held", {7'b0, irq_o}, 8'h01);
    reg_rd(6'h0F, d); chk("R6 sticky bits read", d, 8'h0B);
    chk("R7 pin drops after read", {7'b0, irq_o}, 8'h00);
    reg_rd(6'h0F, d); chk("R7 status cleared", d, 8'h00);
    reg_wr(6'h04, 8'h01);
    chk("R8 active-low idle high", {7'b0, irq_o}, 8'h01);
    pulse_src(8'h08);
    chk("R8 active-low asserted", {7'b0, irq_o}, 8'h00);
    reg_rd(6'h0F, d);
    chk("R7 active-low released", {7'b0, irq_o}, 8'h01);
    reg_wr(6'h04, 8'h00);
  endtask

  task automatic t_frame;
    lqi_i = 8'hC3;
    txb[0] = 8'h60; txb[1] = 8'h05;
    for (int i = 0; i < 5; i++) txb[2+i] = 8'h11 * (i + 1);
    spi_bits(7*8);
    for (int i = 0; i < 9; i++) txb[i] = 8'h00;
    txb[0] = 8'h20;
    spi_bits(9*8);
    chk("R10 length first", rxb[1], 8'h05);
    for (int i = 0; i < 5; i++) chk("R9 payload", rxb[2+i], 8'(8'h11 * (i + 1)));
    chk("R10 link quality after payload", rxb[7], 8'hC3);
    chk("R10 zero after link quality", rxb[8], 8'h00);
    txb[0] = 8'h60; txb[1] = 8'h83; txb[2] = 8'h5A;
    spi_bits(3*8);
    txb[0] = 8'h20; txb[1] = 8'h00;
    spi_bits(2*8);
    chk("R9 length bit 7 dropped", rxb[1], 8'h03);
  endtask

  task automatic t_frame_max;
    lqi_i = 8'h7E;
    txb[0] = 8'h60; txb[1] = 8'd127;
    for (int i = 0; i < 130; i++) txb[2+i] = 8'(i + 1);
    spi_bits(132*8);
    for (int i = 0; i < 131; i++) txb[i] = 8'h00;
    txb[0] = 8'h20;
    spi_bits(131*8);
    chk("R11 length 127", rxb[1], 8'd127);
    chk("R11 first payload not overwritten", rxb[2], 8'd1);
    chk("R11 last payload", rxb[128], 8'd127);
    chk("R11 link quality after 127", rxb[129], 8'h7E);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    txb[0] = 8'h60; txb[1] = 8'h04;
    txb[2] = 8'hAA; txb[3] = 8'hBB; txb[4] = 8'hCC; txb[5] = 8'hDD;
    spi_bits(6*8);
    txb[0] = 8'h60; txb[1] = 8'h04; txb[2] = 8'h01; txb[3] = 8'h02; txb[4] = 8'hFF;
    spi_bits(4*8 + 3);
    for (int i = 0; i < 6; i++) txb[i] = 8'h00;
    txb[0] = 8'h20;
    spi_bits(6*8);
    chk("R12 length kept", rxb[1], 8'h04);
    chk("R12 new byte 0", rxb[2], 8'h01);
    chk("R12 new byte 1", rxb[3], 8'h02);
    chk("R12 partial byte not committed", rxb[4], 8'hCC);
    chk("R12 old byte kept", rxb[5], 8'hDD);
    reg_wr(6'h20, 8'h5A);
    txb[0] = 8'hE0; txb[1] = 8'hFF;
    spi_bits(8 + 5);
    reg_rd(6'h20, d); chk("R12 partial register write", d, 8'h5A);
  endtask

  task automatic t_skip;
    logic [7:0] d;
    txb[0] = 8'h00; txb[1] = 8'hFF; txb[2] = 8'hFF;
    spi_bits(24);
    chk("R13 ignored command returns zero", rxb[1], 8'h00);
    txb[0] = 8'h40; txb[1] = 8'h11; txb[2] = 8'h22;
    spi_bits(24);
    chk("R13 ignored write-like command returns zero", rxb[2], 8'h00);
    reg_rd(6'h20, d); chk("R13 register unchanged", d, 8'h5A);
    txb[0] = 8'h20; txb[1] = 8'h00;
    spi_bits(16);
    chk("R13 frame length unchanged", rxb[1], 8'h04);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_status_byte();
    t_reg_rw();
    t_readonly();
    t_unimpl();
    t_trx_cmd();
    t_irq();
    t_frame();
    t_frame_max();
    t_abort();
    t_skip();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule